// File: doc/BRIEF.md
# Seven-Level Priority Interrupt Controller

The controller gathers interrupt requests from ten peripheral sources and gives the CPU one 3-bit code: the highest priority level that has an enabled pending request. Level 7 is the highest and level 1 the lowest. Code 0 means that nothing is pending. Each maskable source latches a pending bit when its request rises. Software masks sources, reads pending state and clears bits over a small register bus. Several levels carry more than one source, so software reads the status register to find out which source caused the interrupt.

The level-7 source is non-maskable and edge-triggered. Its pending bit clears in one of two ways: when the CPU acknowledges while level 7 is presented, or when software writes its clear bit. An acknowledge pulse also records the level in service on a separate output.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every mask bit is 0 (all sources enabled), no source is pending, and `irq_level_o` and `ack_level_o` are 0.
- R2: A 0-to-1 change of `req_i[k]`, sampled on consecutive clock edges, sets pending bit k at that edge. A request held high sets the bit once and does not set it again after it is cleared.
- R3: A write to address 1 (clear) clears each pending bit whose data bit is 1 and leaves the other pending bits unchanged. If a new rising edge arrives on a source in the same cycle as its clear, the source stays pending.
- R4: `irq_level_o` is the highest level that has a pending, unmasked source, or 0 when there is none. The source-to-level map (bit index to level) is: bit 0 second timer to 1; bits 1, 2, 3 data/interface group to 2; bit 4 scan to 3; bit 5 beam detect and bit 6 first timer to 4; bit 7 optional serial to 5; bit 8 video line FIFO to 6; bit 9 NMI to 7.
- R5: Address 0 holds the mask register, which can be read and written. A mask bit of 1 removes that source from the level computation. The source still latches and is still shown as pending.
- R6: Mask bit 9 cannot be set. Writes to it are ignored and it always reads 0, so the NMI always reaches level 7.
- R7: When `ack_i` is high while `irq_level_o` is 7, the NMI pending bit clears at that edge. A held NMI request does not raise a second event.
- R8: `ack_i` high at a clock edge loads `ack_level_o` with the `irq_level_o` value seen before that edge. Without `ack_i`, `ack_level_o` holds its value.
- R9: Address 2 reads all pending bits. Address 3 reads pending AND NOT mask. Address 1 reads 0. Together these registers separate the sources that share a level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 10 | Per-source request lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 mask, 1 clear, 2 status, 3 active |
| reg_wdata_i | input | 10 | Write data |
| reg_rdata_o | output | 10 | Combinational read data for `reg_addr_i` |
| ack_i | input | 1 | CPU acknowledge pulse |
| irq_level_o | output | 3 | Highest active level, 0 when none |
| ack_level_o | output | 3 | Level captured at the last acknowledge |

## Verification
Directed cases check one thing at a time: both level-4 sources pending, each unmasked alone, so that only the status register tells them apart; a clear and a fresh edge in the same cycle, which shows that the set wins; and a held NMI that is acknowledged and then stays high, which shows that an edge fires only once. Random request toggles mixed with mask writes, clear writes and acknowledges run against a cycle model. This shows whether each code comes from the highest level rather than the lowest or an arbitrary one, and whether masking changes the level without changing the status.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NUM_SRC = 10;
  localparam int NUM_LVL = 7;
  localparam int LVL_W   = $clog2(NUM_LVL + 1);
  localparam int REG_AW  = 2;
  localparam int NMI_IDX = NUM_SRC - 1;

  typedef logic [NUM_SRC-1:0] src_vec_t;
  typedef logic [LVL_W-1:0]   lvl_t;

  typedef enum logic [REG_AW-1:0] {
    REG_MASK = 2'd0,
    REG_CLR  = 2'd1,
    REG_STAT = 2'd2,
    REG_ACT  = 2'd3
  } reg_addr_e;

  localparam src_vec_t MASKABLE = ~(src_vec_t'(1) << NMI_IDX);

  function automatic int src_level(int idx);
    case (idx)
      0:       return 1;
      1, 2, 3: return 2;
      4:       return 3;
      5, 6:    return 4;
      7:       return 5;
      8:       return 6;
      default: return 7;
    endcase
  endfunction

  function automatic src_vec_t lvl_sel(int lvl);
    src_vec_t v = '0;
    for (int i = 0; i < NUM_SRC; i++) v[i] = (src_level(i) == lvl);
    return v;
  endfunction
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch
  import irq_prio_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t req_i,
  input  src_vec_t clr_i,
  output src_vec_t pend_o
);
  src_vec_t req_q, rise;

  assign rise = req_i & ~req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      pend_o <= '0;
    end else begin
      req_q  <= req_i;
      // a fresh edge wins over a same-cycle clear
      pend_o <= (pend_o & ~clr_i) | rise;
    end
  end
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_prio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  src_vec_t          wdata_i,
  input  src_vec_t          pend_i,
  output src_vec_t          mask_o,
  output src_vec_t          clr_o,
  output src_vec_t          rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_o <= '0;
    else if (we_i && addr_i == REG_MASK) mask_o <= wdata_i & MASKABLE;
  end

  assign clr_o = (we_i && addr_i == REG_CLR) ? wdata_i : '0;

  always_comb begin
    unique case (addr_i)
      REG_MASK: rdata_o = mask_o;
      REG_STAT: rdata_o = pend_i;
      REG_ACT:  rdata_o = pend_i & ~mask_o;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc
  import irq_prio_pkg::*;
(
  input  src_vec_t active_i,
  output lvl_t     level_o
);
  logic [NUM_LVL:1] lvl_hit;

  for (genvar l = 1; l <= NUM_LVL; l++) begin : g_lvl
    localparam src_vec_t SEL = lvl_sel(l);
    assign lvl_hit[l] = |(active_i & SEL);
  end

  always_comb begin
    level_o = '0;
    for (int l = 1; l <= NUM_LVL; l++)
      if (lvl_hit[l]) level_o = lvl_t'(l);
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [irq_prio_pkg::NUM_SRC-1:0] req_i,
  input  logic                         reg_we_i,
  input  logic [irq_prio_pkg::REG_AW-1:0]  reg_addr_i,
  input  logic [irq_prio_pkg::NUM_SRC-1:0] reg_wdata_i,
  output logic [irq_prio_pkg::NUM_SRC-1:0] reg_rdata_o,
  input  logic                         ack_i,
  output logic [irq_prio_pkg::LVL_W-1:0]   ack_level_o,
  output logic [irq_prio_pkg::LVL_W-1:0]   irq_level_o
);
  src_vec_t pend_q, mask_q, clr_wr, clr_all;
  logic     nmi_ack;

  assign nmi_ack = ack_i && (irq_level_o == lvl_t'(NUM_LVL));
  assign clr_all = clr_wr | (nmi_ack ? (src_vec_t'(1) << NMI_IDX) : '0);

  irq_src_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .clr_i  (clr_all),
    .pend_o (pend_q)
  );

  irq_reg_file u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .pend_i  (pend_q),
    .mask_o  (mask_q),
    .clr_o   (clr_wr),
    .rdata_o (reg_rdata_o)
  );

  irq_level_enc u_enc (
    .active_i (pend_q & ~mask_q),
    .level_o  (irq_level_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ack_level_o <= '0;
    else if (ack_i) ack_level_o <= irq_level_o;
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_prio_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input src_vec_t          req_i,
  input logic              reg_we_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input src_vec_t          reg_wdata_i,
  input src_vec_t          reg_rdata_o,
  input logic              ack_i,
  input lvl_t              ack_level_o,
  input lvl_t              irq_level_o,
  input src_vec_t          pend_q
);
  assert_ack_capture_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> ack_level_o == $past(irq_level_o));

  assert_ack_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> $stable(ack_level_o));

  assert_nmi_top_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q[NMI_IDX] |-> irq_level_o == lvl_t'(NUM_LVL));

  assert_level_needs_pend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_level_o != '0 |-> pend_q != '0);

  assert_mask_nmi_bit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_addr_i == REG_MASK |-> !reg_rdata_o[NMI_IDX]);

  assert_clear_all_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == REG_CLR && &reg_wdata_i && req_i == '0) |=> pend_q == '0);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .ack_i       (ack_i),
  .ack_level_o (ack_level_o),
  .irq_level_o (irq_level_o),
  .pend_q      (pend_q)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  localparam int NS = 10;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NS-1:0] req = '0;
  logic          we = 1'b0;
  logic [1:0]    addr = 2'd2;
  logic [NS-1:0] wdata = '0;
  logic          ack = 1'b0;
  logic [NS-1:0] rdata;
  logic [2:0]    ack_lvl, lvl;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  logic [NS-1:0] m_pend = '0, m_mask = '0, m_prev = '0;
  logic [2:0]    m_ack = '0;

  always #5 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ack_i(ack), .ack_level_o(ack_lvl), .irq_level_o(lvl)
  );

  function automatic int lvl_of(int i);
    case (i)
      0: return 1; 1, 2, 3: return 2; 4: return 3;
      5, 6: return 4; 7: return 5; 8: return 6; default: return 7;
    endcase
  endfunction

  function automatic logic [2:0] exp_level(logic [NS-1:0] p, logic [NS-1:0] m);
    int best = 0;
    for (int i = 0; i < NS; i++)
      if (p[i] && !m[i] && lvl_of(i) > best) best = lvl_of(i);
    return 3'(best);
  endfunction

  function automatic logic [NS-1:0] exp_rdata(logic [1:0] a);
    case (a)
      2'd0: return m_mask;
      2'd2: return m_pend;
      2'd3: return m_pend & ~m_mask;
      default: return '0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic [NS-1:0] clr;
    logic [2:0] lp = exp_level(m_pend, m_mask);
    clr = (we && addr == 2'd1) ? wdata : '0;
    if (ack && lp == 3'd7) clr[NS-1] = 1'b1;
    if (ack) m_ack = lp;
    m_pend = (m_pend & ~clr) | (req & ~m_prev);
    if (we && addr == 2'd0) m_mask = wdata & {1'b0, {(NS-1){1'b1}}};
    m_prev = req;
  endtask

  task automatic step(logic [NS-1:0] rq, logic w, logic [1:0] a, logic [NS-1:0] wd, logic ak);
    @(negedge clk);
    req = rq; we = w; addr = a; wdata = wd; ack = ak;
    @(posedge clk);
    model_edge();
    #1;
    check("R4 level", 32'(lvl), 32'(exp_level(m_pend, m_mask)));
    check("R8 ack_level", 32'(ack_lvl), 32'(m_ack));
    check(a == 2'd0 ? "R6 mask read" : "R9 register read", 32'(rdata), 32'(exp_rdata(a)));
  endtask

  task automatic rd(logic [1:0] a); step(req, 1'b0, a, '0, 1'b0); endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [NS-1:0] r;
    void'($urandom(32'h1A2B));
    repeat (3) @(posedge clk);
    #1;
    check("R1 level at reset", 32'(lvl), 0);
    check("R1 ack_level at reset", 32'(ack_lvl), 0);
    @(negedge clk) rst_ni = 1'b1;
    rd(2'd0); check("R1 mask reset", 32'(rdata), 0);
    rd(2'd2); check("R1 pend reset", 32'(rdata), 0);

    // R4 shared level 4: beam detect + first timer, status separates them
    step(10'h060, 0, 2'd2, '0, 0);
    check("R4 shared level 4", 32'(lvl), 4);
    check("R9 status both level-4", 32'(rdata), 32'h060);
    step(10'h060, 1, 2'd1, 10'h020, 0);
    rd(2'd2); check("R3 clear one of shared", 32'(rdata), 32'h040);
    check("R3 level stays 4", 32'(lvl), 4);
    // R5 mask hides but keeps pending
    step(10'h060, 1, 2'd0, 10'h040, 0);
    rd(2'd3); check("R5 masked level", 32'(lvl), 0);
    rd(2'd2); check("R5 still pending", 32'(rdata), 32'h040);
    // R2 held request does not re-set
    step(10'h060, 1, 2'd1, 10'h3FF, 0);
    step(10'h060, 0, 2'd2, '0, 0);
    check("R2 held no re-set", 32'(rdata), 0);
    step(10'h000, 1, 2'd0, 10'h000, 0);
    // R3 clear with same-cycle edge: set wins
    step(10'h001, 1, 2'd1, 10'h001, 0);
    rd(2'd2); check("R3 edge beats clear", 32'(rdata[0]), 1);
    check("R4 level 1", 32'(lvl), 1);
    // R6 cannot mask NMI
    step(10'h001, 1, 2'd0, 10'h3FF, 0);
    rd(2'd0); check("R6 mask nmi bit", 32'(rdata), 32'h1FF);
    step(10'h201, 0, 2'd2, '0, 0);
    check("R6 nmi level under full mask", 32'(lvl), 7);
    // R7 ack clears NMI, held NMI does not re-fire
    step(10'h201, 0, 2'd2, '0, 1);
    check("R7 nmi cleared by ack", 32'(rdata[9]), 0);
    check("R8 ack captured 7", 32'(ack_lvl), 7);
    step(10'h201, 0, 2'd2, '0, 0);
    step(10'h201, 0, 2'd2, '0, 0);
    check("R7 held nmi single event", 32'(lvl), 0);
    step(10'h000, 1, 2'd0, 10'h000, 0);
    rd(2'd3); check("R9 active after unmask", 32'(rdata), 32'h001);

    for (int n = 0; n < 3000; n++) begin
      r = req ^ (NS'($urandom) & NS'($urandom) & NS'($urandom));
      case ($urandom_range(0, 5))
        0: step(r, 1'b1, 2'd0, NS'($urandom), 1'b0);
        1: step(r, 1'b1, 2'd1, NS'($urandom), 1'b0);
        2: step(r, 1'b0, 2'($urandom), '0, 1'b1);
        default: step(r, 1'b0, 2'($urandom), '0, 1'b0);
      endcase
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule